// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic core of an 8-bit processor datapath. Each cycle it takes an accumulator value, a second operand and the current flag byte, and it produces a result byte and a new flag byte. A 3-bit code selects one of eight two-operand operations. When the `unary` input is high, the same code instead selects one of the single-operand operations, all of which act on the accumulator.

The result byte and its write strobe are combinational, so the register file can take them in the same cycle. The new flag byte is captured in an internal register on the clock edge that ends a valid cycle. The flag byte keeps a fixed bit layout:

| Bit | Meaning |
|-----|---------|
| 7 | sign |
| 6 | zero |
| 5 | copy of result bit 5 |
| 4 | half-carry |
| 3 | copy of result bit 3 |
| 2 | parity/overflow |
| 1 | subtract |
| 0 | carry |

Top module: `alu8_flags`

## Requirements
- R1: The flag byte uses the layout above. For every operation that updates flags, bits 5 and 3 take bits 5 and 3 of the result byte. For set-carry and complement-carry, the result byte is `a_in`, so those bits come from `a_in`.
- R2: With `unary`=0, the two-operand codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare. The operation uses `a_in` and `b_in`, and the carry input is `f_in` bit 0.
- R3: Add and add-with-carry set sign and zero from the result, carry from bit 8 and half-carry from the carry out of bit 3. Bit 2 is the signed overflow. The subtract flag is 0.
- R4: Subtract, subtract-with-borrow and negate set carry on a borrow out of the byte and half-carry on a borrow out of bit 4. Bit 2 is set when the operand signs differ and the result sign differs from the minuend. The subtract flag is 1.
- R5: AND, XOR and OR clear carry and the subtract flag. Bit 2 is 1 when the result has an even number of ones. Half-carry is 1 for AND and 0 for XOR and OR.
- R6: Compare puts `a_in - b_in` on `res` and sets flags as subtract does, but `res_we` stays 0.
- R7: With `unary`=1, code 0 (increment) and code 1 (decrement) act on `a_in`. They set sign, zero, half-carry and overflow, set the subtract flag to 0 and 1 respectively, and keep carry from `f_in`.
- R8: Unary code 2 (complement) returns `~a_in`. It sets half-carry and subtract to 1 and keeps sign, zero, bit 2 and carry from `f_in`.
- R9: Unary code 3 (negate) returns `0 - a_in` with subtract flags. Code 4 (set carry) sets carry and clears half-carry and subtract. Code 5 (complement carry) inverts carry, moves the old carry into half-carry and clears subtract. Codes 4 and 5 keep sign, zero and bit 2 from `f_in` and do not write.
- R10: Unary codes 6 and 7 are no-ops. `res` equals `a_in`, `res_we` is 0, and the flag register takes `f_in` unchanged.
- R11: `res` and `res_we` are valid in the same cycle as the inputs, and `res_we` is 0 whenever `in_valid` is 0. `flags_q` loads the new flags on the clock edge that ends a valid cycle and holds its value otherwise. Reset clears `flags_q` to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| unary | input | 1 | Selects the single-operand operation group |
| op | input | 3 | Operation code within the group |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| f_in | input | 8 | Incoming flag byte |
| res | output | 8 | Result byte (combinational) |
| res_we | output | 1 | Result write enable (combinational) |
| flags_q | output | 8 | Registered flag byte |

## Verification
`res` and `res_we` depend only on the current inputs. The bench drives each vector on a falling edge and samples them one nanosecond later, before the next rising edge. The flag byte passes through one register, so the bench samples `flags_q` at the falling edge after the capturing rising edge. It applies the next vector only after that sample. Directed cycles with `in_valid` low and a different `f_in` show that `flags_q` holds its value.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         unary,
  input  logic [2:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] f_in,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [W-1:0] flags_q
);
  localparam int HB = W / 2;
  localparam logic [2:0] U_INC = 3'd0, U_DEC = 3'd1, U_CPL = 3'd2,
                         U_NEG = 3'd3, U_SCF = 3'd4, U_CCF = 3'd5;

  logic [W-1:0] x, y, yy, r;
  logic         cin, sub, cc, wr;
  logic [W:0]   s9;
  logic [HB:0]  h5;
  logic         carry, half, ovf, par, zero;
  logic [W-1:0] nf;

  always_comb begin
    x = a_in; y = b_in; cin = 1'b0; sub = 1'b0;
    if (!unary) begin
      cin = op[0] & ~op[2] & f_in[0];
      sub = (op == 3'd2) || (op == 3'd3) || (op == 3'd7);
    end else begin
      case (op)
        U_INC:   y = 'd1;
        U_DEC:   begin y = 'd1; sub = 1'b1; end
        U_NEG:   begin x = '0; y = a_in; sub = 1'b1; end
        default: ;
      endcase
    end
  end

  assign yy    = sub ? ~y : y;
  assign cc    = sub ? ~cin : cin;
  assign s9    = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, cc};
  assign h5    = {1'b0, x[HB-1:0]} + {1'b0, yy[HB-1:0]} + {{HB{1'b0}}, cc};
  assign carry = s9[W] ^ sub;
  assign half  = h5[HB] ^ sub;
  assign ovf   = (x[W-1] == yy[W-1]) && (s9[W-1] != x[W-1]);
  assign par   = ~^r;
  assign zero  = (r == '0);

  always_comb begin
    r  = s9[W-1:0];
    wr = 1'b1;
    nf = {r[W-1], zero, r[5], half, r[3], ovf, sub, carry};
    if (!unary) begin
      case (op)
        3'd4, 3'd5, 3'd6: begin
          r  = (op == 3'd4) ? (a_in & b_in) : (op == 3'd5) ? (a_in ^ b_in) : (a_in | b_in);
          nf = {r[W-1], zero, r[5], op == 3'd4, r[3], par, 2'b00};
        end
        3'd7:    wr = 1'b0;
        default: ;
      endcase
    end else begin
      case (op)
        U_INC, U_DEC: nf = {r[W-1], zero, r[5], half, r[3], ovf, sub, f_in[0]};
        U_CPL: begin
          r  = ~a_in;
          nf = {f_in[7:6], r[5], 1'b1, r[3], f_in[2], 1'b1, f_in[0]};
        end
        U_NEG: ;
        U_SCF: begin
          r = a_in; wr = 1'b0;
          nf = {f_in[7:6], a_in[5], 1'b0, a_in[3], f_in[2], 2'b01};
        end
        U_CCF: begin
          r = a_in; wr = 1'b0;
          nf = {f_in[7:6], a_in[5], f_in[0], a_in[3], f_in[2], 1'b0, ~f_in[0]};
        end
        default: begin
          r = a_in; wr = 1'b0; nf = f_in;
        end
      endcase
    end
  end

  assign res    = r;
  assign res_we = in_valid & wr;

  always_ff @(posedge clk) begin
    if (!rst_n)        flags_q <= '0;
    else if (in_valid) flags_q <= nf;
  end

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(flags_q));
  a_r11_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !res_we);
  a_r5_logic_clears_cn: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !unary && (op == 3'd4 || op == 3'd5 || op == 3'd6)) |=> (flags_q[1:0] == 2'b00));
  a_r6_cp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !unary && op == 3'd7) |-> !res_we);
  a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unary && (op == U_INC || op == U_DEC)) |=> (flags_q[0] == $past(f_in[0])));
  a_r3_zero_tracks_res: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!unary || op == U_INC || op == U_DEC || op == U_NEG))
      |=> (flags_q[6] == ($past(res) == '0)));
  a_r9_scf_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unary && op == U_SCF) |=> (flags_q[0] && !flags_q[1] && !flags_q[4]));
endmodule

// File: tb/alu8_flags_tb_top.sv
`timescale 1ns/1ps
module alu8_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, unary = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] a_in = '0, b_in = '0, f_in = '0;
  logic [7:0] res, flags_q;
  logic res_we;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu8_flags dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .unary(unary), .op(op),
    .a_in(a_in), .b_in(b_in), .f_in(f_in),
    .res(res), .res_we(res_we), .flags_q(flags_q)
  );

  // {req, unary, op, a, b, f_in, exp_res, exp_we, exp_flags}
  localparam int NV = 22;
  localparam logic [48:0] VEC [NV] = '{
    {4'd3,  1'b0, 3'd0, 8'h44, 8'h11, 8'h00, 8'h55, 1'b1, 8'h00}, // R3 plain add
    {4'd3,  1'b0, 3'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 1'b1, 8'h94}, // R3 overflow
    {4'd2,  1'b0, 3'd1, 8'hFF, 8'h00, 8'h01, 8'h00, 1'b1, 8'h51}, // R2 adc uses carry in
    {4'd4,  1'b0, 3'd2, 8'h10, 8'h01, 8'h00, 8'h0F, 1'b1, 8'h1A}, // R4 nibble borrow, R1 bit3
    {4'd4,  1'b0, 3'd3, 8'h00, 8'h00, 8'h01, 8'hFF, 1'b1, 8'hBB}, // R4 sbc borrow
    {4'd4,  1'b0, 3'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 1'b1, 8'h3E}, // R4 signed overflow
    {4'd5,  1'b0, 3'd4, 8'hF0, 8'h3C, 8'hFF, 8'h30, 1'b1, 8'h34}, // R5 and
    {4'd5,  1'b0, 3'd5, 8'h5A, 8'h5A, 8'hFF, 8'h00, 1'b1, 8'h44}, // R5 xor
    {4'd5,  1'b0, 3'd6, 8'h01, 8'h02, 8'h00, 8'h03, 1'b1, 8'h04}, // R5 or
    {4'd6,  1'b0, 3'd7, 8'h20, 8'h30, 8'h00, 8'hF0, 1'b0, 8'hA3}, // R6 compare less
    {4'd6,  1'b0, 3'd7, 8'h42, 8'h42, 8'h00, 8'h00, 1'b0, 8'h42}, // R6 compare equal
    {4'd7,  1'b1, 3'd0, 8'h7F, 8'h00, 8'h01, 8'h80, 1'b1, 8'h95}, // R7 inc overflow
    {4'd7,  1'b1, 3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 8'h50}, // R7 inc wrap
    {4'd7,  1'b1, 3'd1, 8'h80, 8'h00, 8'h01, 8'h7F, 1'b1, 8'h3F}, // R7 dec overflow
    {4'd7,  1'b1, 3'd1, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 8'h42}, // R7 dec to zero
    {4'd8,  1'b1, 3'd2, 8'h0F, 8'h00, 8'hC5, 8'hF0, 1'b1, 8'hF7}, // R8 complement
    {4'd9,  1'b1, 3'd3, 8'h01, 8'h00, 8'h00, 8'hFF, 1'b1, 8'hBB}, // R9 negate
    {4'd9,  1'b1, 3'd3, 8'h80, 8'h00, 8'h00, 8'h80, 1'b1, 8'h87}, // R9 negate 80h
    {4'd1,  1'b1, 3'd4, 8'h28, 8'h00, 8'hC6, 8'h28, 1'b0, 8'hED}, // R1 copy bits from a, R9 scf
    {4'd9,  1'b1, 3'd5, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 8'h10}, // R9 ccf 1->0
    {4'd9,  1'b1, 3'd5, 8'h00, 8'h00, 8'h10, 8'h00, 1'b0, 8'h01}, // R9 ccf 0->1
    {4'd10, 1'b1, 3'd6, 8'hAA, 8'h00, 8'h5A, 8'hAA, 1'b0, 8'h5A}  // R10 reserved code
  };

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "flags after reset", flags_q, 8'h00);
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[48:45]);
      in_valid = 1'b1; unary = v[44]; op = v[43:41];
      a_in = v[40:33]; b_in = v[32:25]; f_in = v[24:17];
      #1;
      check(rq, "res", res, v[16:9]);
      check(rq, "res_we", {7'd0, res_we}, {7'd0, v[8]});
      @(negedge clk);
      check(rq, "flags", flags_q, v[7:0]);
    end
    // R11: idle cycle holds flags and blocks the write strobe
    in_valid = 1'b0; unary = 1'b0; op = 3'd0; a_in = 8'h01; b_in = 8'h01; f_in = 8'hFF;
    #1;
    check("R11", "res_we idle", {7'd0, res_we}, 8'h00);
    @(negedge clk);
    check("R11", "flags held", flags_q, 8'h5A);
    // R11: a new valid op after idle loads, then reset clears
    in_valid = 1'b1; op = 3'd4; a_in = 8'h00; b_in = 8'h00; f_in = 8'h00;
    @(negedge clk);
    check("R11", "flags after and-zero", flags_q, 8'h54);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R11", "flags after mid reset", flags_q, 8'h00);
    rst_n = 1'b1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule